// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block recovers bytes from an asynchronous serial line and keeps them for a processor to read. The line is first synchronized to the system clock. It is then examined on a 16x oversampling tick that comes from outside the block. A falling edge on the line begins a candidate frame. That candidate is dropped if the start bit does not read low at the middle of the bit. Each bit's value is the majority of three samples taken around the centre of the bit.

A completed frame is copied from the shift register into a separate holding register. The copy happens only if the receive-complete flag is clear. Because the two registers are separate, the next frame can be shifted in while the processor has not yet read the previous byte.

The bus has two addresses. The control address holds the enable bit, the flag and the last stop bit. The data address is shared with the transmitter: a write to it produces a load strobe and a byte toward the transmitter, and a read from it returns the holding register.

Top module: `serial_rx_dbuf`

## Requirements
- R1: After reset the control word reads 0x00, the holding register reads 0x00, the flag output is low and no transmitter strobe is issued.
- R2: A frame is one low start bit, 8 data bits sent least significant bit first, and one stop bit. Each bit lasts 16 ticks. A valid frame delivers its byte to the holding register.
- R3: A transfer into the holding register sets the flag, which is bit 1 of the control word. Only a control write with bit 1 = 0 clears the flag. A control write with bit 1 = 1 leaves it unchanged.
- R4: If the flag is still set when a frame completes, that frame is discarded and the holding register and the flag keep their values.
- R5: A start bit whose majority reads high at its centre is rejected. No byte is delivered, and the receiver waits for the next falling edge.
- R6: Each bit is sampled on ticks 7, 8 and 9 of its 16 ticks (tick 0 is the tick on which the start edge is first seen). The bit takes the value held by at least two of the three samples.
- R7: Address select 0 is the data address. A write there issues a one-cycle strobe carrying the written byte toward the transmitter and leaves the holding register unchanged. A read there returns the holding register. Read data appears one clock after the select is applied.
- R8: Bit 0 of the control word enables reception. While it is 0, line activity delivers nothing.
- R9: The sampled stop bit of a transferred frame is kept in bit 2 of the control word. A low stop bit does not block the transfer.
- R10: If the flag is cleared while a frame is being shifted in, that frame is transferred when it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| os_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| bus_sel_i | input | 1 | Register select: 0 = data, 1 = control |
| bus_wr_i | input | 1 | Write strobe for the selected register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data of the selected register |
| rx_data_o | output | 8 | Holding register contents |
| rx_full_o | output | 1 | Receive-complete flag |
| tx_load_o | output | 1 | One-cycle load strobe toward the transmitter |
| tx_data_o | output | 8 | Byte written to the data address |

## Verification
The hardest case to reach from the ports is a frame that arrives while an earlier byte is still unread. The outcome depends on whether the flag is cleared before that frame's stop bit or only after it. To cover both, the bench switches off its automatic scoreboard consumer. It then sends back-to-back frames with the flag left set, and it also sends one frame while a concurrent thread clears the flag partway through the data bits. The stimulus is placed tick by tick, so the bench can flip a single vote sample or shorten a start pulse to end just before or inside the voting window.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_FLAG_BIT = 1;
  localparam int CTRL_STOP_BIT = 2;

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  // idle level of the line is high
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import serial_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              stop_o
);

  localparam int CNT_W    = $clog2(OSR);
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int VOTE_MID = OSR / 2;

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bitn;
  logic [1:0]        votes;
  logic [DATA_W-1:0] shreg;
  logic              at_v0, at_v1, at_v2, bit_val;

  assign at_v0   = (cnt == CNT_W'(VOTE_MID - 1));
  assign at_v1   = (cnt == CNT_W'(VOTE_MID));
  assign at_v2   = (cnt == CNT_W'(VOTE_MID + 1));
  assign bit_val = vote3({rxd_i, votes});

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      votes  <= '0;
      shreg  <= '0;
      done_o <= 1'b0;
      stop_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (tick_i) begin
        if (state == ST_IDLE) begin
          // the tick that first sees the line low is index 0
          if (!rxd_i) begin
            state <= ST_START;
            cnt   <= CNT_W'(1);
          end
        end else begin
          cnt <= (cnt == CNT_W'(OSR - 1)) ? '0 : cnt + 1'b1;
          if (at_v0) votes[0] <= rxd_i;
          if (at_v1) votes[1] <= rxd_i;
          if (at_v2) begin
            case (state)
              ST_START: begin
                if (bit_val) state <= ST_IDLE;
                else begin
                  state <= ST_DATA;
                  bitn  <= '0;
                end
              end
              ST_DATA: begin
                shreg <= {bit_val, shreg[DATA_W-1:1]};
                if (bitn == IDX_W'(DATA_W - 1)) state <= ST_STOP;
                else                            bitn  <= bitn + 1'b1;
              end
              ST_STOP: begin
                stop_o <= bit_val;
                done_o <= 1'b1;
                state  <= ST_IDLE;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign data_o = shreg;

  // R5: a high centre vote on the start bit drops the candidate frame
  a_r5_false_start: assert property (@(posedge clk) disable iff (rst)
    (en_i && tick_i && state == ST_START && at_v2 && bit_val) |=> (state == ST_IDLE && !done_o));

  // R2: completion only follows the stop bit
  a_r2_done_after_stop: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(state) == ST_STOP));

  // R8: disabled receiver stays idle and reports nothing
  a_r8_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (state == ST_IDLE && !done_o));

endmodule

// File: rtl/srx_holdbuf.sv
module srx_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              frame_stop_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] hold_data_o,
  output logic              hold_stop_o,
  output logic              flag_o
);

  // a completing frame wins over a clear in the same cycle only when
  // the flag was already clear; otherwise the frame is dropped
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data_o <= '0;
      hold_stop_o <= 1'b0;
      flag_o      <= 1'b0;
    end else if (frame_done_i && !flag_o) begin
      hold_data_o <= frame_data_i;
      hold_stop_o <= frame_stop_i;
      flag_o      <= 1'b1;
    end else if (clr_i) begin
      flag_o <= 1'b0;
    end
  end

  a_r3_flag_on_transfer: assert property (@(posedge clk) disable iff (rst)
    (frame_done_i && !flag_o) |=> flag_o);

  a_r3_no_self_set: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && !frame_done_i) |=> !flag_o);

  a_r3_clear_by_write: assert property (@(posedge clk) disable iff (rst)
    (clr_i && flag_o) |=> !flag_o);

  a_r4_keep_unread: assert property (@(posedge clk) disable iff (rst)
    (frame_done_i && flag_o) |=> ($stable(hold_data_o) && $stable(hold_stop_o)));

endmodule

// File: rtl/serial_rx_dbuf.sv
module serial_rx_dbuf
  import serial_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_i,
  input  logic              os_tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_data_o
);

  logic              rxd_sync;
  logic              rx_en;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_stop;
  logic              hold_stop;
  logic              ctrl_wr, data_wr, flag_clr;
  logic [REG_W-1:0]  ctrl_word;

  assign ctrl_wr  = bus_wr_i && bus_sel_i;
  assign data_wr  = bus_wr_i && !bus_sel_i;
  assign flag_clr = ctrl_wr && !bus_wdata_i[CTRL_FLAG_BIT];

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd_i),
    .dout(rxd_sync)
  );

  srx_framer #(.OSR(OSR), .DATA_W(DATA_W)) u_framer (
    .clk   (clk),
    .rst   (rst),
    .en_i  (rx_en),
    .tick_i(os_tick_i),
    .rxd_i (rxd_sync),
    .done_o(frame_done),
    .data_o(frame_data),
    .stop_o(frame_stop)
  );

  srx_holdbuf #(.DATA_W(DATA_W)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .frame_done_i(frame_done),
    .frame_data_i(frame_data),
    .frame_stop_i(frame_stop),
    .clr_i       (flag_clr),
    .hold_data_o (rx_data_o),
    .hold_stop_o (hold_stop),
    .flag_o      (rx_full_o)
  );

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_EN_BIT]   = rx_en;
    ctrl_word[CTRL_FLAG_BIT] = rx_full_o;
    ctrl_word[CTRL_STOP_BIT] = hold_stop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en       <= 1'b0;
      tx_load_o   <= 1'b0;
      tx_data_o   <= '0;
      bus_rdata_o <= '0;
    end else begin
      tx_load_o <= data_wr;
      if (data_wr) tx_data_o <= bus_wdata_i[DATA_W-1:0];
      if (ctrl_wr) rx_en     <= bus_wdata_i[CTRL_EN_BIT];
      bus_rdata_o <= bus_sel_i ? ctrl_word : REG_W'(rx_data_o);
    end
  end

  // R7: transmitter strobe only follows a data-address write
  a_r7_tx_strobe: assert property (@(posedge clk) disable iff (rst)
    tx_load_o |-> $past(bus_wr_i && !bus_sel_i));

  // R7: a data-address write never disturbs the receive side
  a_r7_rx_untouched: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !frame_done) |=> $stable(rx_data_o));

endmodule

// File: tb/serial_rx_dbuf_test.sv
`timescale 1ns/1ps
module serial_rx_dbuf_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       tick = 1'b0;
  logic       sel = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, rx_data, tx_data;
  logic       rx_full, tx_load;

  int errors = 0;
  int checks = 0;
  int tdiv = 0;
  bit mon_on = 1'b0;
  int mon_seen = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
  end

  serial_rx_dbuf uut (
    .clk(clk), .rst(rst), .rxd_i(rxd), .os_tick_i(tick),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .rx_data_o(rx_data), .rx_full_o(rx_full),
    .tx_load_o(tx_load), .tx_data_o(tx_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!tick);
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) wait_tick();
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop, input logic [7:0] glitch);
    if (mon_on) exp_q.push_back(d);
    wait_tick();
    @(negedge clk);
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) begin
      if (glitch[i]) begin
        hold(d[i], 8);
        hold(~d[i], 1);
        hold(d[i], 7);
      end else begin
        hold(d[i], 16);
      end
    end
    hold(stop, 16);
    hold(1'b1, 6);
  endtask

  task automatic bus_write(input logic s, input logic [7:0] d);
    @(negedge clk);
    sel = s; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic s, output logic [7:0] d);
    @(negedge clk);
    sel = s;
    @(negedge clk);
    d = rdata;
  endtask

  // scoreboard consumer: compares each delivered byte and releases the buffer
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && rx_full) begin
        if (exp_q.size() == 0) chk("R2 unexpected byte", rx_data, 32'hFFFF);
        else chk("R2 byte order", rx_data, exp_q.pop_front());
        mon_seen++;
        bus_write(1'b1, 8'h01);
      end
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    bus_read(1'b1, r);   chk("R1 ctrl reset", r, 8'h00);
    bus_read(1'b0, r);   chk("R1 data reset", r, 8'h00);
    chk("R1 flag reset", rx_full, 1'b0);
    chk("R1 no tx strobe", tx_load, 1'b0);

    bus_write(1'b1, 8'h01);
    bus_read(1'b1, r);   chk("R8 enable readback", r, 8'h01);

    // R2 plain frames and R6 single-sample corruption, via scoreboard
    mon_on = 1'b1;
    send_frame(8'hA5, 1'b1, 8'h00);
    send_frame(8'h3C, 1'b1, 8'h00);
    send_frame(8'h00, 1'b1, 8'h00);
    send_frame(8'hFF, 1'b1, 8'h00);
    send_frame(8'h81, 1'b1, 8'h00);
    send_frame(8'h5A, 1'b1, 8'h08);   // R6 one vote flipped in bit 3
    send_frame(8'h96, 1'b1, 8'hFF);   // R6 middle vote flipped in every bit
    repeat (20) @(negedge clk);
    mon_on = 1'b0;
    chk("R2 all delivered", mon_seen, 7);
    chk("R6 queue drained", exp_q.size(), 0);

    // R5 short start pulses
    wait_tick(); @(negedge clk);
    hold(1'b0, 6); hold(1'b1, 40);
    chk("R5 short start rejected", rx_full, 1'b0);
    hold(1'b0, 8); hold(1'b1, 40);
    chk("R5 start ending at vote rejected", rx_full, 1'b0);
    send_frame(8'h42, 1'b1, 8'h00);
    chk("R5 recovery flag", rx_full, 1'b1);
    chk("R5 recovery data", rx_data, 8'h42);

    // R3 clearing rules
    bus_write(1'b1, 8'h03);
    chk("R3 write one keeps flag", rx_full, 1'b1);
    bus_write(1'b1, 8'h01);
    chk("R3 write zero clears", rx_full, 1'b0);

    // R4 overrun discards the new frame
    send_frame(8'h11, 1'b1, 8'h00);
    send_frame(8'h22, 1'b1, 8'h00);
    chk("R4 old byte kept", rx_data, 8'h11);
    chk("R4 flag still set", rx_full, 1'b1);

    // R10 clear arrives while the next frame is shifting
    fork
      send_frame(8'h33, 1'b1, 8'h00);
      begin
        repeat (70) wait_tick();
        bus_write(1'b1, 8'h01);
      end
    join
    chk("R10 shifted frame transferred", rx_data, 8'h33);
    chk("R10 flag set", rx_full, 1'b1);
    bus_write(1'b1, 8'h01);

    // R9 stop bit capture
    send_frame(8'h5B, 1'b0, 8'h00);
    chk("R9 data with low stop", rx_data, 8'h5B);
    bus_read(1'b1, r);   chk("R9 low stop in ctrl", r, 8'h03);
    bus_write(1'b1, 8'h01);
    send_frame(8'h6C, 1'b1, 8'h00);
    bus_read(1'b1, r);   chk("R9 high stop in ctrl", r, 8'h07);

    // R8 disabled receiver
    bus_write(1'b1, 8'h00);
    send_frame(8'h77, 1'b1, 8'h00);
    chk("R8 disabled no flag", rx_full, 1'b0);
    chk("R8 disabled data kept", rx_data, 8'h6C);
    bus_write(1'b1, 8'h01);
    send_frame(8'h78, 1'b1, 8'h00);
    chk("R8 re-enabled data", rx_data, 8'h78);

    // R7 shared data address
    @(negedge clk);
    sel = 1'b0; wr = 1'b1; wdata = 8'hC3;
    @(negedge clk);
    wr = 1'b0;
    chk("R7 tx strobe", tx_load, 1'b1);
    chk("R7 tx data", tx_data, 8'hC3);
    @(negedge clk);
    chk("R7 strobe one cycle", tx_load, 1'b0);
    bus_read(1'b0, r);   chk("R7 read returns rx buffer", r, 8'h78);
    chk("R7 flag untouched", rx_full, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule